// File: doc/BRIEF.md
# Partial-Decode Programmable Modulus Divider

This block is a binary ripple-free up-counter of 17 stages that divides its input clock by a modulus chosen at build time. It does not compare the full count against a terminal value. Instead it watches a small group of stages: the lowest four and the top two. When those six stages show a preset pattern, a jam pulse is raised. On the next rising edge the jam pulse forces a chosen set of stages to 1 and another set to 0, and this replaces the normal increment. The count therefore skips part of its natural 2^17 sequence. The skip can go forward or backward, depending on the masks.

The top stage is the divided output. Its period equals the programmed modulus. Its high time follows from where the jump lands, so the duty cycle is generally far from 50%. A second output passes the input clock straight through, so that the oscillator frequency can be observed without loading it. The default masks divide a 3,579,545 Hz clock down to about 60 Hz, which is a modulus of 59,659. All state is held in static flip-flops, so the clock may stop for any length of time.

Top module: `pmd_divider`

## Requirements
- R1: While `rst` is high at a rising edge of `clk_in`, all stages are cleared to 0, so `div_out` reads 0 after that edge.
- R2: When no jam is pending, each rising edge of `clk_in` adds one to the 17-bit count, with carries running through all stages.
- R3: The jam pulse depends only on stages 0–3, 15 and 16 (0-based), matched against `DEC_PAT`; stages 4–14 have no effect on it. With the default pattern (stages 16,15 = 0 and stages 3..0 = 4'b1000), the first jam follows state 8, so `div_out` first rises on the 9th edge after reset is released.
- R4: On the edge after a jam pulse, every stage named in `SET_MASK` becomes 1, every stage named in `CLR_MASK` becomes 0, and all other stages keep their values. No increment is applied on that edge.
- R5: `div_out` is stage 16 of the count. With the default masks it is high for 59,650 of each 59,659 input cycles.
- R6: `tune_out` carries the input clock unchanged: it is high while `clk_in` is high and low while it is low.
- R7: With the defaults (`DEC_PAT` = 17'h00008, `SET_MASK` = 17'h116F6, `CLR_MASK` = 0), consecutive rising edges of `div_out` are exactly 59,659 input edges apart.
- R8: With `DEC_PAT` = 17'h10003, `SET_MASK` = 17'h0C000 and `CLR_MASK` = 17'h10000, the count jumps back from 0x10003 to 0x0C003. `div_out` first rises on the 65,536th edge after reset, stays high for 4 cycles, and repeats every 16,385 edges.
- R9: When reset is applied in the middle of a period and then released, counting restarts from zero, and the default build again first rises on the 9th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; the count advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset of all stages |
| tune_out | output | 1 | Buffered copy of the input clock |
| div_out | output | 1 | Top counter stage; the divided output |

## Verification
The bench instantiates the block twice and runs both instances side by side. The first instance uses the default masks. Its jam is a forward jump that sets stages, giving the 59,659 modulus and a 9-cycle low phase. The second instance sets and clears stages in one jam, which moves the count backward. This version checks the clear path, the carry into the top stage after 65,536 plain increments, and a short 4-cycle high time, all within about 100,000 cycles.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  localparam int MAX_W = 32;
  typedef logic [MAX_W-1:0] word_t;

  // Stages that take part in the jam decode: the low four and the top two.
  function automatic word_t decode_mask(input int w);
    word_t m;
    m        = '0;
    m[3:0]   = 4'hF;
    m[w-1]   = 1'b1;
    m[w-2]   = 1'b1;
    return m;
  endfunction

  // State loaded on a jam: clear first, then set; untouched stages keep value.
  function automatic word_t jam_value(input word_t q, input word_t s, input word_t c);
    return (q & ~c) | s;
  endfunction

  // Plain successor state.
  function automatic word_t step_value(input word_t q);
    return q + word_t'(1);
  endfunction
endpackage

// File: rtl/pmd_decode.sv
module pmd_decode #(
  parameter int          W    = 17,
  parameter logic [W-1:0] MASK = '0,
  parameter logic [W-1:0] PAT  = '0
) (
  input  logic [W-1:0] q,
  output logic         hit
);
  logic [W-1:0] bit_ok;

  // Each stage either matches the pattern or is excluded from the decode.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_ok[i] = ~MASK[i] | ~(q[i] ^ PAT[i]);
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/pmd_jam.sv
module pmd_jam #(
  parameter int           W        = 17,
  parameter logic [W-1:0] SET_MASK = '0,
  parameter logic [W-1:0] CLR_MASK = '0
) (
  input  logic [W-1:0] q,
  input  logic         hit,
  output logic [W-1:0] nxt
);
  import pmd_pkg::*;

  logic [W-1:0] jam_nxt;
  logic [W-1:0] inc_nxt;

  assign jam_nxt = W'(jam_value(word_t'(q), word_t'(SET_MASK), word_t'(CLR_MASK)));
  assign inc_nxt = W'(step_value(word_t'(q)));

  // The jam replaces the increment on the edge it is applied.
  assign nxt = hit ? jam_nxt : inc_nxt;
endmodule

// File: rtl/pmd_stages.sv
module pmd_stages #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // One static flip-flop per stage.
  for (genvar i = 0; i < W; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= d[i];
    end
  end
endmodule

// File: rtl/pmd_divider.sv
module pmd_divider #(
  parameter int           W        = 17,
  parameter logic [W-1:0] DEC_PAT  = W'(32'h0000_0008),
  parameter logic [W-1:0] SET_MASK = W'(32'h0001_16F6),
  parameter logic [W-1:0] CLR_MASK = W'(32'h0000_0000)
) (
  input  logic clk_in,
  input  logic rst,
  output logic tune_out,
  output logic div_out
);
  import pmd_pkg::*;

  localparam logic [W-1:0] DEC_MASK = W'(decode_mask(W));

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         jam_hit;

  pmd_decode #(
    .W    (W),
    .MASK (DEC_MASK),
    .PAT  (DEC_PAT)
  ) u_decode (
    .q   (cnt_q),
    .hit (jam_hit)
  );

  pmd_jam #(
    .W        (W),
    .SET_MASK (SET_MASK),
    .CLR_MASK (CLR_MASK)
  ) u_jam (
    .q   (cnt_q),
    .hit (jam_hit),
    .nxt (cnt_d)
  );

  pmd_stages #(
    .W (W)
  ) u_stages (
    .clk (clk_in),
    .rst (rst),
    .d   (cnt_d),
    .q   (cnt_q)
  );

  assign tune_out = clk_in;
  assign div_out  = cnt_q[W-1];
endmodule

// File: rtl/pmd_divider_chk.sv
module pmd_divider_chk #(
  parameter int           W        = 17,
  parameter logic [W-1:0] DEC_MASK = '0,
  parameter logic [W-1:0] SET_MASK = '0,
  parameter logic [W-1:0] CLR_MASK = '0
) (
  input logic         clk_in,
  input logic         rst,
  input logic [W-1:0] cnt_q,
  input logic         jam_hit
);
  localparam logic [W-1:0] KEEP = ~(SET_MASK | CLR_MASK);

  AST_RESET_CLEARS: assert property (@(posedge clk_in)
    rst |=> (cnt_q == '0)); // R1

  AST_PLAIN_STEP: assert property (@(posedge clk_in) disable iff (rst)
    !jam_hit |=> (cnt_q == W'($past(cnt_q) + 1'b1))); // R2

  AST_DECODE_FREE_STAGES: assert property (@(posedge clk_in) disable iff (rst)
    $stable(cnt_q & DEC_MASK) |-> $stable(jam_hit)); // R3

  AST_JAM_FORCES: assert property (@(posedge clk_in) disable iff (rst)
    jam_hit |=> (((cnt_q & SET_MASK) == SET_MASK) &&
                 ((cnt_q & CLR_MASK) == '0) &&
                 ((cnt_q & KEEP) == ($past(cnt_q) & KEEP)))); // R4
endmodule

bind pmd_divider pmd_divider_chk #(
  .W        (W),
  .DEC_MASK (DEC_MASK),
  .SET_MASK (SET_MASK),
  .CLR_MASK (CLR_MASK)
) u_chk (
  .clk_in  (clk_in),
  .rst     (rst),
  .cnt_q   (cnt_q),
  .jam_hit (jam_hit)
);

// File: tb/pmd_divider_tb.sv
module pmd_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tune_a, div_a, tune_b, div_b;
  int unsigned cyc = 0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  pmd_divider u_dut (
    .clk_in   (clk),
    .rst      (rst),
    .tune_out (tune_a),
    .div_out  (div_a)
  );

  pmd_divider #(
    .W        (17),
    .DEC_PAT  (17'h10003),
    .SET_MASK (17'h0C000),
    .CLR_MASK (17'h10000)
  ) u_dut_alt (
    .clk_in   (clk),
    .rst      (rst),
    .tune_out (tune_b),
    .div_out  (div_b)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check("R1", "default div_out in reset", div_a, 0);
    check("R1", "alt div_out in reset", div_b, 0);
  endtask

  task automatic t_default_period();
    int unsigned r1, f1, r2;
    do @(negedge clk); while (div_a !== 1'b1);
    r1 = cyc;
    check("R3", "default first rise edge", r1, 9);
    do @(negedge clk); while (div_a !== 1'b0);
    f1 = cyc;
    check("R5", "default high time", f1 - r1, 59650);
    do @(negedge clk); while (div_a !== 1'b1);
    r2 = cyc;
    check("R7", "default period", r2 - r1, 59659);
  endtask

  task automatic t_alt_period();
    int unsigned r1, f1, r2;
    do @(negedge clk); while (div_b !== 1'b1);
    r1 = cyc;
    check("R2", "alt first rise edge", r1, 65536);
    do @(negedge clk); while (div_b !== 1'b0);
    f1 = cyc;
    check("R4", "alt high time", f1 - r1, 4);
    do @(negedge clk); while (div_b !== 1'b1);
    r2 = cyc;
    check("R8", "alt period", r2 - r1, 16385);
  endtask

  task automatic t_tune();
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #(CLK_PERIOD/4);
      check("R6", "tune_out high phase", tune_a, 1);
      check("R6", "alt tune_out high phase", tune_b, 1);
      @(negedge clk); #(CLK_PERIOD/4);
      check("R6", "tune_out low phase", tune_a, 0);
    end
  endtask

  task automatic t_mid_reset();
    int unsigned r1;
    repeat (1234) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "default div_out after mid reset", div_a, 0);
    check("R1", "alt div_out after mid reset", div_b, 0);
    rst = 1'b0;
    do @(negedge clk); while (div_a !== 1'b1);
    r1 = cyc;
    check("R9", "default first rise after mid reset", r1, 9);
    repeat (100) @(negedge clk);
    check("R9", "alt still low after restart", div_b, 0);
  endtask

  initial begin
    t_reset_state();
    rst = 1'b0;
    fork
      t_default_period();
      t_alt_period();
    join
    t_tune();
    t_mid_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule